// File: doc/BRIEF.md
# Tagged Register Status File

This block holds a small set of architectural data registers for an out-of-order core. Each register carries a busy flag and a producer tag next to its value. When an instruction issues, the issue side names its destination register and the functional unit that will compute the result. The register is then busy and remembers that unit's tag. Finished results come back over one shared result broadcast: a tag and a value in the same cycle. Every busy register whose stored tag equals the broadcast tag takes the value and becomes ready.

Renaming falls out of the tag compare. A second issue to a register that is already busy overwrites its tag. The result of the earlier producer then matches nothing and is dropped, so only the newest pending write reaches the register.

Consumers read registers through independent combinational read ports. Each port returns the busy flag, the tag and the value. While busy is high the consumer must wait on the tag. Otherwise the value is valid. A broadcast that resolves the register being read in the same cycle is forwarded straight to the port as ready data.

Top module: `tagreg_status_file`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the busy flag, the tag and the value of every register to zero.
- R2: An issue (`iss_en` high) makes register `iss_reg` busy with tag `iss_tag` from the next clock edge on. Its value does not change.
- R3: A broadcast (`bc_en` high) whose tag equals the stored tag of a busy register writes `bc_val` into that register and clears its busy flag at the next edge.
- R4: A broadcast leaves a register's busy flag, tag and value unchanged if the register is not busy or if its stored tag differs from `bc_tag`.
- R5: A single broadcast resolves, in the same cycle, every busy register that waits on its tag.
- R6: When an issue and a matching broadcast target the same register in the same cycle, the issue wins. The register stays busy with the new tag, and the broadcast value is discarded for that register.
- R7: After a register is re-issued under a new tag, a broadcast of its earlier tag has no effect on it. Only the broadcast of the newest tag commits a value.
- R8: Read port p returns, combinationally, the busy flag, tag and value of register `rd_addr[p*3 +: 3]`, packed at `rd_busy[p]`, `rd_tag[p*3 +: 3]` and `rd_val[p*16 +: 16]`.
- R9: If the register being read is busy and its stored tag equals a broadcast in the same cycle, the port reports busy low and the broadcast value. The tag output still shows the stored tag.
- R10: The two read ports are independent and may address any registers, including the same one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_en | input | 1 | Issue strobe |
| iss_reg | input | 3 | Destination register of the issuing instruction |
| iss_tag | input | 3 | Tag of the functional unit that will produce the value |
| bc_en | input | 1 | Result broadcast valid |
| bc_tag | input | 3 | Tag of the broadcasting unit |
| bc_val | input | 16 | Broadcast result value |
| rd_addr | input | 6 | Read addresses, 3 bits per port |
| rd_busy | output | 2 | Per-port busy flag (bypass applied) |
| rd_tag | output | 6 | Per-port stored tag, 3 bits per port |
| rd_val | output | 32 | Per-port value (bypass applied), 16 bits per port |

## Verification
On every cycle, the assertions check the following. Busy rises only on an issue to that register. An issue always leaves the named register busy with its tag. A matching broadcast clears busy and stores the value. Any other register keeps its value, and each read port follows the stored state or the bypass.

The bench's scenarios show the behaviour that needs sequences of cycles. These are the renaming case where a stale tag is ignored, one tag resolving several registers at once, the issue-versus-broadcast collision, and a reset in the middle of a run. The bench compares all registers on both ports in every cycle against its own model.

// File: rtl/tagreg_status_file.sv
module tagreg_status_file #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 3,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_en,
  input  logic [AW-1:0]     iss_reg,
  input  logic [TW-1:0]     iss_tag,
  input  logic              bc_en,
  input  logic [TW-1:0]     bc_tag,
  input  logic [DW-1:0]     bc_val,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD-1:0]    rd_busy,
  output logic [NRD*TW-1:0] rd_tag,
  output logic [NRD*DW-1:0] rd_val
);

  logic [NREG-1:0]         busy_q;
  logic [NREG-1:0][TW-1:0] tag_q;
  logic [NREG-1:0][DW-1:0] val_q;
  logic [NREG-1:0]         hit;
  logic [NREG-1:0]         own;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = bc_en && busy_q[g] && (tag_q[g] == bc_tag);
    assign own[g] = iss_en && (iss_reg == AW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q[g] <= 1'b0;
        tag_q[g]  <= '0;
        val_q[g]  <= '0;
      end else if (own[g]) begin
        busy_q[g] <= 1'b1;
        tag_q[g]  <= iss_tag;
      end else if (hit[g]) begin
        busy_q[g] <= 1'b0;
        val_q[g]  <= bc_val;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [AW-1:0] a;
    assign a                   = rd_addr[p*AW +: AW];
    assign rd_busy[p]          = busy_q[a] & ~hit[a];
    assign rd_tag[p*TW +: TW]  = tag_q[a];
    assign rd_val[p*DW +: DW]  = hit[a] ? bc_val : val_q[a];
  end

endmodule

// File: rtl/tagreg_status_chk.sv
module tagreg_status_chk #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int TW   = 3,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    iss_en,
  input logic [AW-1:0]           iss_reg,
  input logic [TW-1:0]           iss_tag,
  input logic                    bc_en,
  input logic [TW-1:0]           bc_tag,
  input logic [DW-1:0]           bc_val,
  input logic [NRD*AW-1:0]       rd_addr,
  input logic [NRD-1:0]          rd_busy,
  input logic [NRD*DW-1:0]       rd_val,
  input logic [NREG-1:0]         busy_q,
  input logic [NREG-1:0][TW-1:0] tag_q,
  input logic [NREG-1:0][DW-1:0] val_q
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (busy_q == '0)); // R1

  AST_ISSUE_TAKES: assert property (@(posedge clk) disable iff (rst)
    iss_en |=> (busy_q[$past(iss_reg)] && tag_q[$past(iss_reg)] == $past(iss_tag))); // R6

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    AST_BUSY_FROM_ISSUE: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_q[g]) |-> ($past(iss_en) && $past(iss_reg) == AW'(g))); // R2

    AST_MATCH_COMMITS: assert property (@(posedge clk) disable iff (rst)
      (bc_en && busy_q[g] && tag_q[g] == bc_tag && !(iss_en && iss_reg == AW'(g)))
      |=> (!busy_q[g] && val_q[g] == $past(bc_val))); // R3

    AST_STALE_IGNORED: assert property (@(posedge clk) disable iff (rst)
      !(bc_en && busy_q[g] && tag_q[g] == bc_tag) |=> $stable(val_q[g])); // R4
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    logic [AW-1:0] a;
    logic          byp;
    assign a   = rd_addr[p*AW +: AW];
    assign byp = bc_en && busy_q[a] && (tag_q[a] == bc_tag);

    AST_READ_BYPASS: assert property (@(posedge clk) disable iff (rst)
      byp |-> (!rd_busy[p] && rd_val[p*DW +: DW] == bc_val)); // R9

    AST_READ_PLAIN: assert property (@(posedge clk) disable iff (rst)
      !byp |-> (rd_busy[p] == busy_q[a] && rd_val[p*DW +: DW] == val_q[a])); // R8
  end

endmodule

bind tagreg_status_file tagreg_status_chk #(
  .NREG(NREG), .DW(DW), .TW(TW), .NRD(NRD)
) u_chk (
  .clk(clk), .rst(rst), .iss_en(iss_en), .iss_reg(iss_reg), .iss_tag(iss_tag),
  .bc_en(bc_en), .bc_tag(bc_tag), .bc_val(bc_val), .rd_addr(rd_addr),
  .rd_busy(rd_busy), .rd_val(rd_val), .busy_q(busy_q), .tag_q(tag_q), .val_q(val_q)
);

// File: tb/test_tagreg_status_file.sv
`timescale 1ns/100ps
module test_tagreg_status_file;
  localparam int NREG = 8, DW = 16, TW = 3, NRD = 2, AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_en = 1'b0;
  logic [AW-1:0] iss_reg = '0;
  logic [TW-1:0] iss_tag = '0;
  logic bc_en = 1'b0;
  logic [TW-1:0] bc_tag = '0;
  logic [DW-1:0] bc_val = '0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic [NRD-1:0] rd_busy;
  logic [NRD*TW-1:0] rd_tag;
  logic [NRD*DW-1:0] rd_val;

  always #4 clk = ~clk;

  tagreg_status_file i_tagreg_status_file (
    .clk(clk), .rst(rst), .iss_en(iss_en), .iss_reg(iss_reg), .iss_tag(iss_tag),
    .bc_en(bc_en), .bc_tag(bc_tag), .bc_val(bc_val), .rd_addr(rd_addr),
    .rd_busy(rd_busy), .rd_tag(rd_tag), .rd_val(rd_val)
  );

  logic          mbusy [NREG];
  logic [TW-1:0] mtag  [NREG];
  logic [DW-1:0] mval  [NREG];
  int n_chk = 0, n_fail = 0;
  string prev = "R1";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(string lbl, logic rs, logic ie, int ir, int it,
                      logic be, int bt, int bv);
    @(negedge clk);
    rst = rs; iss_en = ie; iss_reg = AW'(ir); iss_tag = TW'(it);
    bc_en = be; bc_tag = TW'(bt); bc_val = DW'(bv);
    if (!rs) begin
      for (int r = 0; r < NREG; r++) begin
        int r1 = NREG - 1 - r;
        logic h0, h1;
        rd_addr = {AW'(r1), AW'(r)};
        #0.3;
        h0 = be && mbusy[r]  && mtag[r]  == TW'(bt);
        h1 = be && mbusy[r1] && mtag[r1] == TW'(bt);
        chk(h0 ? "R9" : prev, "port0 busy", 32'(rd_busy[0]), 32'(mbusy[r] && !h0));
        chk(h0 ? "R9" : prev, "port0 val",  32'(rd_val[0 +: DW]), 32'(h0 ? DW'(bv) : mval[r]));
        chk("R8", "port0 tag", 32'(rd_tag[0 +: TW]), 32'(mtag[r]));
        chk("R10", "port1 busy", 32'(rd_busy[1]), 32'(mbusy[r1] && !h1));
        chk("R10", "port1 val",  32'(rd_val[DW +: DW]), 32'(h1 ? DW'(bv) : mval[r1]));
        chk("R10", "port1 tag",  32'(rd_tag[TW +: TW]), 32'(mtag[r1]));
      end
    end
    @(posedge clk);
    for (int r = 0; r < NREG; r++) begin
      logic h = be && mbusy[r] && mtag[r] == TW'(bt);
      if (rs) begin mbusy[r] = 0; mtag[r] = '0; mval[r] = '0; end
      else if (ie && ir == r) begin mbusy[r] = 1; mtag[r] = TW'(it); end
      else if (h) begin mbusy[r] = 0; mval[r] = DW'(bv); end
    end
    prev = lbl;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int r = 0; r < NREG; r++) begin mbusy[r] = 'x; mtag[r] = 'x; mval[r] = 'x; end
    step("R1", 1, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0, 0);
    // R2/R3 sweep: every register with every tag
    for (int r = 0; r < NREG; r++)
      for (int t = 0; t < 8; t++) begin
        step("R2", 0, 1, r, t, 0, 0, 0);
        step("R4", 0, 0, 0, 0, 1, t ^ 1, 16'hDEAD);
        step("R3", 0, 0, 0, 0, 1, t, r * 4096 + t * 17 + 3);
      end
    // R4: broadcast to idle registers
    step("R4", 0, 0, 0, 0, 1, 2, 16'h5555);
    // R5: three registers wait on tag 6
    step("R2", 0, 1, 1, 6, 0, 0, 0);
    step("R2", 0, 1, 4, 6, 0, 0, 0);
    step("R2", 0, 1, 7, 6, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 6, 16'h6161);
    // R7: rename, stale tag ignored, newest tag commits
    step("R2", 0, 1, 3, 1, 0, 0, 0);
    step("R2", 0, 1, 3, 5, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 1, 16'h1111);
    step("R7", 0, 0, 0, 0, 1, 5, 16'h5555);
    // R6: issue and matching broadcast collide
    step("R2", 0, 1, 2, 4, 0, 0, 0);
    step("R2", 0, 1, 6, 4, 0, 0, 0);
    step("R6", 0, 1, 2, 0, 1, 4, 16'h4444);
    step("R6", 0, 0, 0, 0, 1, 4, 16'hBBBB);
    step("R6", 0, 0, 0, 0, 1, 0, 16'h0F0F);
    // mixed traffic
    for (int k = 0; k < 1500; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R8", 0, lf[0] & lf[1], lf[4:2], lf[7:5], lf[8] | lf[9], lf[12:10], {lf[7:0], lf[15:8]});
    end
    // R1: reset in the middle of a run
    step("R2", 0, 1, 5, 3, 0, 0, 0);
    step("R1", 1, 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 1, 3, 16'h3333);
    step("R4", 0, 0, 0, 0, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule